// File: doc/BRIEF.md
# Double-Buffered Multi-Channel PWM Generator

This block is a peripheral that produces pulse-width modulated outputs on several pins at once. Two independent 8-bit timebases run at a programmable division of the system clock. Each one counts from zero up to its own period value, then clears and starts a new period. When that happens it sets a sticky event flag. Every channel picks one of the two timebases and holds a 10-bit duty value. The eight upper bits sit in a duty register and the two lowest bits sit in the channel control register. The duty value is copied into a shadow compare register only at the moment its timebase starts a new period, so software may rewrite it at any time without producing a broken pulse.

Each enabled output rises at the start of a period and falls when the 10-bit position reaches the latched duty. The position is the timer count with a two-bit sub-step from the prescaler appended, so duty can be set in quarter steps. A duty value beyond the end of the period keeps the pin high for the whole cycle. Software reaches every register through a simple single-cycle write strobe and a combinational read port.

Top module: `pwm_bank`

## Requirements
- R1: A timebase is started by control bit 2 and steps once every 4, 16 or 64 clocks for prescale field (bits 1:0) values 0, 1 or 2/3. When the count equals the period register at a step, the count clears to 0 and the sticky flag (bit 0 of the flag register) sets. A period therefore lasts 4×(period+1) steps of the sub-count. Any write to the flag register clears the flag, and a period event in the same cycle wins over the clear.
- R2: The 10-bit duty is {duty register, channel control bits 5:4}. An enabled channel copies it into its shadow register on each period event of its timebase. A duty write during a period leaves the current pulse unchanged and takes effect from the next period.
- R3: An enabled output goes high at the start of each period and stays high while the position {count, sub-count} is below the shadow duty. The pulse therefore lasts duty × (clocks per sub-step) clocks.
- R4: A duty of 0 gives an output that is never high. A duty of 4×(period+1) or more gives an output that is high for the whole period.
- R5: A channel runs in PWM mode only when its control bits 3:0 equal 0xC. In any other mode its output is low from the next cycle, and period events neither load its shadow nor raise it. After re-enabling, the output stays low until the next period event.
- R6: A write to the count register takes effect on the next edge and restarts the prescaler. The current period then ends when the new count reaches the period. If the new position is at or past the shadow duty, the output falls at once.
- R7: If a write to the count or to the period leaves the count above the period, the timebase keeps counting through 0xFF, wraps to 0, and only then matches the period.
- R8: Control bit 6 of a channel selects timebase 0 (value 0) or timebase 1 (value 1).
- R9: Channels on the same timebase with equal duty produce identical outputs in every cycle.
- R10: After reset all registers read 0 and all outputs are low. Register map: timebase t at 4t+{0 count, 1 period, 2 control, 3 flag}, channel n at 0x10+2n (duty) and 0x11+2n (control, bits 6:0). Registers read back the written value, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one register written per asserted cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH (4) | One PWM output per channel |

## Verification
The pulse width is measured over a full period across a table of period, duty, prescale and timebase settings. Duty 0, duty just under the period end, duty just past it and the maximum code separate the compare boundary from the 100% case. Nonzero duty LSBs show the quarter-step join, and the three prescale settings show the sub-count scaling. A twin channel with the same setting is compared cycle by cycle, and settings on the second timebase catch a broken select. Directed sequences rewrite duty mid-pulse, write the count past the duty, lower the period below the count, whose wrap through 0xFF gives a period length far from that of a clamped counter, and disable and re-enable a channel across a period event.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
  localparam int CNT_W = 8;
  localparam int SUB_W = 2;
  localparam int POS_W = CNT_W + SUB_W;
  localparam int PS_W  = 6;
  localparam logic [3:0] MODE_PWM = 4'hC;

  // last prescaler value before a timer step (4, 16 or 64 clocks per step)
  function automatic logic [PS_W-1:0] ps_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd3;
      2'd1:    return 6'd15;
      default: return 6'd63;
    endcase
  endfunction

  // quarter-step position taken from the top two prescaler bits in use
  function automatic logic [SUB_W-1:0] ps_sub(input logic [1:0] sel,
                                               input logic [PS_W-1:0] pc);
    case (sel)
      2'd0:    return pc[1:0];
      2'd1:    return pc[3:2];
      default: return pc[5:4];
    endcase
  endfunction

  function automatic logic [POS_W-1:0] duty_word(input logic [CNT_W-1:0] hi,
                                                 input logic [SUB_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic mode_is_pwm(input logic [3:0] mode);
    return mode == MODE_PWM;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       ps_sel,
  input  logic [CNT_W-1:0] period,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [SUB_W-1:0] sub,
  output logic             tick,
  output logic             match
);
  logic [PS_W-1:0] pc;

  assign tick  = run && (pc >= ps_limit(ps_sel));
  assign match = tick && (count == period) && !load;
  assign sub   = ps_sub(ps_sel, pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      pc    <= '0;
    end else if (load) begin
      count <= load_val;
      pc    <= '0;
    end else if (tick) begin
      pc    <= '0;
      count <= match ? '0 : count + 1'b1;
    end else if (run) begin
      pc    <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [POS_W-1:0] duty_buf,
  input  logic             period_start,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] shadow,
  output logic             pin
);
  logic active;
  logic below;

  assign below = pos < shadow;
  assign pin   = enable && active && below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= 1'b0;
    end else if (!enable) begin
      active <= 1'b0;
    end else if (period_start) begin
      shadow <= duty_buf;
      active <= 1'b1;
    end else if (!below) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int NUM_TB   = 2;
  localparam int TB_SPAN  = 4;
  localparam int OFS_CNT  = 0;
  localparam int OFS_PER  = 1;
  localparam int OFS_CTL  = 2;
  localparam int OFS_FLG  = 3;
  localparam int CH_BASE  = 16;
  localparam int CH_SPAN  = 2;
  localparam int OFS_DUTY = 0;
  localparam int OFS_CCTL = 1;

  logic [NUM_TB-1:0][CNT_W-1:0] tb_period, tb_count;
  logic [NUM_TB-1:0][2:0]       tb_ctrl;
  logic [NUM_TB-1:0][SUB_W-1:0] tb_sub;
  logic [NUM_TB-1:0]            tb_tick, tb_match, tb_load, tb_flag;

  logic [NUM_CH-1:0][CNT_W-1:0] ch_duty;
  logic [NUM_CH-1:0][6:0]       ch_ctrl;
  logic [NUM_CH-1:0]            ch_en, ch_sel, ch_start;
  logic [NUM_CH-1:0][POS_W-1:0] ch_buf, ch_shadow, ch_pos;

  for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
    localparam int BASE = TB_SPAN * t;
    logic [CNT_W-1:0] per_q;
    logic [2:0]       ctl_q;
    logic             flg_q;

    assign tb_load[t] = bus_wr && (bus_addr == ADDR_W'(BASE + OFS_CNT));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q <= '0;
        ctl_q <= '0;
        flg_q <= 1'b0;
      end else begin
        if (bus_wr && bus_addr == ADDR_W'(BASE + OFS_PER)) per_q <= bus_wdata;
        if (bus_wr && bus_addr == ADDR_W'(BASE + OFS_CTL)) ctl_q <= bus_wdata[2:0];
        if (tb_match[t])
          flg_q <= 1'b1;
        else if (bus_wr && bus_addr == ADDR_W'(BASE + OFS_FLG))
          flg_q <= 1'b0;
      end
    end

    assign tb_period[t] = per_q;
    assign tb_ctrl[t]   = ctl_q;
    assign tb_flag[t]   = flg_q;

    pwm_timebase u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctl_q[2]),
      .ps_sel   (ctl_q[1:0]),
      .period   (per_q),
      .load     (tb_load[t]),
      .load_val (bus_wdata),
      .count    (tb_count[t]),
      .sub      (tb_sub[t]),
      .tick     (tb_tick[t]),
      .match    (tb_match[t])
    );
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int BASE = CH_BASE + CH_SPAN * n;
    logic [CNT_W-1:0] duty_q;
    logic [6:0]       ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_q <= '0;
        ctl_q  <= '0;
      end else begin
        if (bus_wr && bus_addr == ADDR_W'(BASE + OFS_DUTY)) duty_q <= bus_wdata;
        if (bus_wr && bus_addr == ADDR_W'(BASE + OFS_CCTL)) ctl_q  <= bus_wdata[6:0];
      end
    end

    assign ch_duty[n]  = duty_q;
    assign ch_ctrl[n]  = ctl_q;
    assign ch_en[n]    = mode_is_pwm(ctl_q[3:0]);
    assign ch_sel[n]   = ctl_q[6];
    assign ch_buf[n]   = duty_word(duty_q, ctl_q[5:4]);
    assign ch_start[n] = tb_match[ch_sel[n]];
    assign ch_pos[n]   = {tb_count[ch_sel[n]], tb_sub[ch_sel[n]]};

    pwm_channel u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (ch_en[n]),
      .duty_buf     (ch_buf[n]),
      .period_start (ch_start[n]),
      .pos          (ch_pos[n]),
      .shadow       (ch_shadow[n]),
      .pin          (pwm_out[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NUM_TB; t++) begin
      if (bus_addr == ADDR_W'(TB_SPAN*t + OFS_CNT)) bus_rdata = tb_count[t];
      if (bus_addr == ADDR_W'(TB_SPAN*t + OFS_PER)) bus_rdata = tb_period[t];
      if (bus_addr == ADDR_W'(TB_SPAN*t + OFS_CTL)) bus_rdata = {5'b0, tb_ctrl[t]};
      if (bus_addr == ADDR_W'(TB_SPAN*t + OFS_FLG)) bus_rdata = {7'b0, tb_flag[t]};
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_SPAN*n + OFS_DUTY)) bus_rdata = ch_duty[n];
      if (bus_addr == ADDR_W'(CH_BASE + CH_SPAN*n + OFS_CCTL)) bus_rdata = {1'b0, ch_ctrl[n]};
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_TB = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_TB-1:0]            tb_tick,
  input logic [NUM_TB-1:0]            tb_match,
  input logic [NUM_TB-1:0]            tb_load,
  input logic [NUM_TB-1:0]            tb_flag,
  input logic [NUM_TB-1:0][CNT_W-1:0] tb_count,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            ch_start,
  input logic [NUM_CH-1:0][POS_W-1:0] ch_buf,
  input logic [NUM_CH-1:0][POS_W-1:0] ch_shadow,
  input logic [NUM_CH-1:0]            pwm_out
);
  for (genvar t = 0; t < NUM_TB; t++) begin : g_tb_chk
    // R1
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tb_match[t] |=> tb_flag[t]);
    // R1
    period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tb_match[t] |=> tb_count[t] == '0);
    // R7
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_tick[t] && !tb_match[t] && !tb_load[t])
        |=> tb_count[t] == CNT_W'($past(tb_count[t]) + 1));
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch_chk
    // R2
    shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[n] && ch_start[n]) |=> ch_shadow[n] == $past(ch_buf[n]));
    // R2
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_start[n] |=> $stable(ch_shadow[n]));
    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[n]) |-> $past(ch_start[n]) && $past(ch_en[n]));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .NUM_TB(NUM_TB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tb_tick   (tb_tick),
  .tb_match  (tb_match),
  .tb_load   (tb_load),
  .tb_flag   (tb_flag),
  .tb_count  (tb_count),
  .ch_en     (ch_en),
  .ch_start  (ch_start),
  .ch_buf    (ch_buf),
  .ch_shadow (ch_shadow),
  .pwm_out   (pwm_out)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;
  localparam int NCH = 4;

  typedef struct packed {
    logic [7:0] per;
    logic [9:0] duty;
    logic [1:0] ps;
    logic       sel;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'd15, 10'd32,   2'd0, 1'b0},
    '{8'd15, 10'd0,    2'd0, 1'b0},
    '{8'd15, 10'd63,   2'd0, 1'b0},
    '{8'd15, 10'd64,   2'd0, 1'b0},
    '{8'd15, 10'd1023, 2'd0, 1'b0},
    '{8'd7,  10'd10,   2'd1, 1'b0},
    '{8'd3,  10'd13,   2'd2, 1'b0},
    '{8'd31, 10'd126,  2'd0, 1'b1},
    '{8'd0,  10'd1,    2'd0, 1'b1},
    '{8'd0,  10'd5,    2'd0, 1'b1},
    '{8'd9,  10'd22,   2'd1, 1'b1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     addr = '0;
  logic [7:0]     wdata = '0;
  logic           wr = 1'b0;
  logic [7:0]     rdata;
  logic [NCH-1:0] pout;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH)) i_pwm_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pwm_out   (pout)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge; returns at the following negedge
  task automatic wreg(input int a, input int d);
    addr  = 8'(a);
    wdata = 8'(d);
    wr    = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic rreg(input int a, output int v);
    addr = 8'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic wait_flag(input int t, output int n);
    addr = 8'(4*t + 3);
    n = 0;
    #1;
    while (rdata[0] !== 1'b1 && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_high(input int ch, input int cycles, output int hi);
    hi = 0;
    for (int j = 0; j < cycles; j++) begin
      if (pout[ch] === 1'b1) hi++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v, n, hi, diff, f, steps, expv, c;
    string req;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state and readback
    check("R10 outputs after reset", int'(pout), 0);
    rreg(0, v);  check("R10 count after reset", v, 0);
    rreg(3, v);  check("R10 flag after reset", v, 0);
    rreg(23, v); check("R10 ctrl after reset", v, 0);
    @(negedge clk);
    wreg(5, 8'hA5);
    rreg(5, v);  check("R10 period readback", v, 8'hA5);
    wreg(23, 8'h6C);
    rreg(23, v); check("R10 ctrl readback", v, 8'h6C);
    rreg(8'h40, v); check("R10 unmapped read", v, 0);
    @(negedge clk);

    // table walk: R1 R3 R4 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      c = VECS[i].sel ? 1 : 0;
      f = (VECS[i].ps == 2'd0) ? 1 : (VECS[i].ps == 2'd1) ? 4 : 16;
      steps = 4 * (int'(VECS[i].per) + 1);
      expv = f * ((int'(VECS[i].duty) < steps) ? int'(VECS[i].duty) : steps);
      wreg(4*c + 2, 4 | int'(VECS[i].ps));
      wreg(4*c + 1, int'(VECS[i].per));
      for (int k = 0; k < 2; k++) begin
        wreg(16 + 2*(c + 2*k), int'(VECS[i].duty[9:2]));
        wreg(17 + 2*(c + 2*k), (c << 6) | (int'(VECS[i].duty[1:0]) << 4) | 8'h0C);
      end
      wreg(4*c, 0);
      wreg(4*c + 3, 0);
      wait_flag(c, n);
      check("R1 period event reached", int'(n < 40000), 1);
      hi = 0;
      diff = 0;
      for (int j = 0; j < f * steps; j++) begin
        if (pout[c] === 1'b1) hi++;
        if (pout[c] !== pout[c+2]) diff++;
        @(negedge clk);
      end
      if (VECS[i].duty == 10'd0 || int'(VECS[i].duty) >= steps) req = "R4 high time";
      else if (VECS[i].sel) req = "R8 high time on timebase 1";
      else if (VECS[i].ps != 2'd0) req = "R1 high time with prescale";
      else req = "R3 high time";
      check(req, hi, expv);
      check("R9 equal duty twins differ", diff, 0);
    end

    // directed set-up: timebase 0, period 15, div 4, ch0 duty 32
    wreg(2, 4);
    wreg(1, 15);
    wreg(16, 8);
    wreg(17, 8'h0C);
    wreg(0, 0);
    wreg(3, 0);
    wait_flag(0, n);

    // R2 duty rewrite mid-period keeps current pulse
    check("R2 high at period start", int'(pout[0]), 1);
    wreg(16, 4);
    count_high(0, 63, hi);
    check("R2 current period unchanged", hi + 1, 32);
    count_high(0, 64, hi);
    check("R2 new duty next period", hi, 16);

    // R6 count write past duty
    check("R6 high before count write", int'(pout[0]), 1);
    wreg(0, 12);
    check("R6 falls at once", int'(pout[0]), 0);
    wreg(3, 0);
    wait_flag(0, n);
    check("R6 shortened period", n, 15);

    // R7 period lowered below count
    wreg(0, 10);
    wreg(1, 5);
    wreg(3, 0);
    wait_flag(0, n);
    check("R7 count wraps through 0xFF", n, 1006);

    // R5 disable and re-enable
    wreg(1, 15);
    check("R5 high while enabled", int'(pout[0]), 1);
    wreg(17, 8'h20);
    check("R5 low after disable", int'(pout[0]), 0);
    wreg(16, 2);
    wreg(3, 0);
    wait_flag(0, n);
    check("R5 ignores period event when off", int'(pout[0]), 0);
    wreg(17, 8'h0C);
    check("R5 stays low after re-enable", int'(pout[0]), 0);
    wreg(3, 0);
    wait_flag(0, n);
    count_high(0, 64, hi);
    check("R5 new duty after re-enable", hi, 8);

    summary();
    $finish;
  end
endmodule